// File: doc/BRIEF.md
# Cipher Key and Mode Register Block

This block keeps the 64-bit secret key and the one-bit encryption mode for a pipelined 32-bit RISC core with added security instructions. The write-back stage hands it already-decoded requests. One strobe writes the low 32-bit half of the key, another writes the high half, and a third writes the mode. The two key-load instructions are load-word variants with no destination register. The mode instruction is jump-format, and its 26-bit argument takes the place of the jump target: any nonzero argument turns encryption on, and zero turns it off.

The assembled key and the crypt-enable flag feed the instruction-fetch decryptor and the memory-stage cipher units. The key holds its value until software loads it again. A newly written key half needs two cycles to settle. During that window the block raises a busy flag. If a mode-enable request arrives inside the window, the block asks the pipeline to stall until the key is in place. A key-valid flag shows when both halves have been written since reset.

Top module: `crypt_key_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `key` is zero and `crypt_en`, `key_valid`, `key_busy` and `stall_req` are 0.
- R2: When `wr_key_lo` is high at a clock edge, `key[31:0]` takes `wr_data` after that edge. `key[63:32]` is unchanged unless `wr_key_hi` is also high.
- R3: When `wr_key_hi` is high at a clock edge, `key[63:32]` takes `wr_data` after that edge. `key[31:0]` is unchanged unless `wr_key_lo` is also high.
- R4: At an edge where neither key strobe is high, `key` keeps its value, including across mode writes.
- R5: `key_valid` goes to 1 only after both halves have been written since reset, in either order or in the same cycle. It then stays at 1 until reset.
- R6: A mode write whose `mode_arg` is nonzero sets `crypt_en` to 1 after the edge, provided it is not stalled. A mode write whose `mode_arg` is zero clears `crypt_en` after the edge, whatever the state of the settle window.
- R7: After an edge with a key-half write, `key_busy` is 1 for exactly `SETTLE_CYC` (default 2) sampled cycles and then returns to 0, unless another key write restarts the window.
- R8: A mode write with a nonzero argument raises `stall_req` in the same cycle if `key_busy` is 1 or a key strobe is high. While stalled, `crypt_en` does not change. The earliest accepted enable after a high-half load is therefore the third edge after it.
- R9: `stall_req` is 0 whenever `wr_mode` is 0 or `mode_arg` is zero.
- R10: When both key strobes are high in the same cycle, both halves take `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_key_lo | input | 1 | Decoded write strobe for the low key half |
| wr_key_hi | input | 1 | Decoded write strobe for the high key half |
| wr_data | input | 32 | Key half data from write-back |
| wr_mode | input | 1 | Decoded mode-instruction strobe |
| mode_arg | input | 26 | Mode argument; nonzero enables, zero disables |
| key | output | 64 | Assembled cipher key |
| crypt_en | output | 1 | Encryption enable flag |
| key_valid | output | 1 | Both halves written since reset |
| key_busy | output | 1 | Key settle window active |
| stall_req | output | 1 | Combinational stall request for a premature mode enable |

## Verification
The assertions assume the pipeline holds a stalled mode request stable until `stall_req` drops. They also assume the strobes are clean decoded pulses, sampled at the rising edge. The bench changes every input only on the falling edge. It keeps a stalled mode request applied, unchanged, until the stall clears. It issues key writes singly, back to back, in both orders and simultaneously, so each case of the settle window and the valid flag is reached through the ports.

// File: rtl/crypt_key_pkg.sv
package crypt_key_pkg;

  // Index of each key half inside the strobe vector and the key word
  typedef enum int unsigned {
    HALF_LO = 0,
    HALF_HI = 1
  } key_half_e;

  localparam int unsigned NUM_HALVES = 2;

  // Nonzero argument means "enable"
  function automatic logic arg_enables(input logic [25:0] arg);
    return |arg;
  endfunction

endpackage

// File: rtl/key_half_reg.sv
module key_half_reg #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] q,
  output logic              loaded
);

  logic [HALF_W-1:0] q_nxt;
  logic              loaded_nxt;

  always_comb begin
    q_nxt      = q;
    loaded_nxt = loaded;
    if (wr_en) begin
      q_nxt      = wr_data;
      loaded_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      loaded <= 1'b0;
    end else begin
      q      <= q_nxt;
      loaded <= loaded_nxt;
    end
  end

  // R2/R3: a written half carries the written data
  p_half_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data));

  // R4: an unwritten half holds
  p_half_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  // R5: the loaded mark never drops outside reset
  p_loaded_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);

endmodule

// File: rtl/key_settle_timer.sv
module key_settle_timer #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  output logic busy
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  assign cnt_en = key_wr || (cnt != '0);

  always_comb begin
    cnt_nxt = cnt;
    if (key_wr) begin
      cnt_nxt = CNT_LOAD;
    end else if (cnt != '0) begin
      cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  assign busy = (cnt != '0);

  // R7: a key write opens the settle window
  p_window_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> busy);

  // R7: without a new write the window only shrinks
  p_window_shrink_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr && !busy |=> !busy);

endmodule

// File: rtl/crypt_mode_ctrl.sv
module crypt_mode_ctrl #(
  parameter int unsigned ARG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic [ARG_W-1:0] mode_arg,
  input  logic             key_busy,
  input  logic             key_wr,
  output logic             crypt_en,
  output logic             stall_req
);

  logic want_on;
  logic accept;
  logic crypt_nxt;

  assign want_on   = |mode_arg;
  assign stall_req = wr_mode && want_on && (key_busy || key_wr);
  assign accept    = wr_mode && !stall_req;

  always_comb begin
    crypt_nxt = crypt_en;
    if (accept) begin
      crypt_nxt = want_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crypt_en <= 1'b0;
    end else if (accept) begin
      crypt_en <= crypt_nxt;
    end
  end

  // R6: an accepted nonzero argument enables
  p_mode_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode && (mode_arg != '0) && !stall_req |=> crypt_en);

  // R6: a zero argument disables regardless of the window
  p_mode_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode && (mode_arg == '0) |=> !crypt_en);

  // R8: a stalled request leaves the flag alone
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> crypt_en == $past(crypt_en));

  // R9: only a nonzero mode request can stall
  p_stall_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> wr_mode && (mode_arg != '0));

endmodule

// File: rtl/crypt_key_ctrl.sv
module crypt_key_ctrl
  import crypt_key_pkg::*;
#(
  parameter int unsigned HALF_W     = 32,
  parameter int unsigned ARG_W      = 26,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_key_lo,
  input  logic                         wr_key_hi,
  input  logic [HALF_W-1:0]            wr_data,
  input  logic                         wr_mode,
  input  logic [ARG_W-1:0]             mode_arg,
  output logic [NUM_HALVES*HALF_W-1:0] key,
  output logic                         crypt_en,
  output logic                         key_valid,
  output logic                         key_busy,
  output logic                         stall_req
);

  localparam int unsigned KEY_W = NUM_HALVES * HALF_W;

  logic [NUM_HALVES-1:0] half_wr;
  logic [NUM_HALVES-1:0] half_loaded;
  logic                  any_key_wr;

  assign half_wr[HALF_LO] = wr_key_lo;
  assign half_wr[HALF_HI] = wr_key_hi;
  assign any_key_wr       = |half_wr;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    key_half_reg #(.HALF_W(HALF_W)) u_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (half_wr[g]),
      .wr_data (wr_data),
      .q       (key[g*HALF_W +: HALF_W]),
      .loaded  (half_loaded[g])
    );
  end

  assign key_valid = &half_loaded;

  key_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_wr (any_key_wr),
    .busy   (key_busy)
  );

  crypt_mode_ctrl #(.ARG_W(ARG_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_mode),
    .mode_arg  (mode_arg),
    .key_busy  (key_busy),
    .key_wr    (any_key_wr),
    .crypt_en  (crypt_en),
    .stall_req (stall_req)
  );

  // R4: the full key is frozen across edges without a key strobe
  p_key_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_key_lo && !wr_key_hi |=> $stable(key));

  // R5: valid cannot rise without a key write on that edge
  p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid && !wr_key_lo && !wr_key_hi |=> !key_valid);

  // R8: an enabling request during a settle window stalls
  p_busy_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_busy && wr_mode && (mode_arg != '0) |-> stall_req);

  // R10: concurrent writes place the same word in both halves
  p_dual_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key_lo && wr_key_hi |=> key[KEY_W-1:HALF_W] == key[HALF_W-1:0]);

endmodule

// File: tb/crypt_key_ctrl_tb.sv
module crypt_key_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_key_lo, wr_key_hi, wr_mode;
  logic [31:0] wr_data;
  logic [25:0] mode_arg;
  logic [63:0] key;
  logic        crypt_en, key_valid, key_busy, stall_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  crypt_key_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_key_lo(wr_key_lo), .wr_key_hi(wr_key_hi),
    .wr_data(wr_data), .wr_mode(wr_mode), .mode_arg(mode_arg), .key(key),
    .crypt_en(crypt_en), .key_valid(key_valid), .key_busy(key_busy),
    .stall_req(stall_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_key_lo = 0; wr_key_hi = 0; wr_mode = 0; wr_data = '0; mode_arg = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 key", key, 64'h0);
    chk("R1 flags", {crypt_en, key_valid, key_busy, stall_req}, 4'b0000);
  endtask

  task automatic t_lo_then_hi();
    do_reset();
    wr_key_lo = 1; wr_data = 32'h5450414c; step(); idle();
    chk("R2 lo load", key, 64'h00000000_5450414c);
    chk("R5 not valid after one half", key_valid, 1'b0);
    step(); step();
    wr_key_hi = 1; wr_data = 32'h4b495241; step(); idle();
    chk("R3 hi load", key, 64'h4b495241_5450414c);
    chk("R5 valid after both", key_valid, 1'b1);
  endtask

  task automatic t_hi_then_lo_order();
    do_reset();
    wr_key_hi = 1; wr_data = 32'hdeadbeef; step(); idle();
    chk("R3 hi alone", key, 64'hdeadbeef_00000000);
    chk("R5 not valid", key_valid, 1'b0);
    wr_key_lo = 1; wr_data = 32'h01234567; step(); idle();
    chk("R2 lo keeps hi", key, 64'hdeadbeef_01234567);
    chk("R5 valid either order", key_valid, 1'b1);
  endtask

  task automatic t_hold_and_mode();
    logic [63:0] k;
    k = key;
    wr_data = 32'hffffffff; step(); step();
    chk("R4 hold without strobe", key, k);
    wr_mode = 1; mode_arg = 26'h0; step(); idle();
    chk("R4 hold across mode write", key, k);
    chk("R5 valid sticky", key_valid, 1'b1);
  endtask

  task automatic t_settle_window();
    do_reset();
    wr_key_hi = 1; wr_data = 32'h11111111; step(); idle();
    chk("R7 busy cycle 1", key_busy, 1'b1);
    step();
    chk("R7 busy cycle 2", key_busy, 1'b1);
    step();
    chk("R7 busy cleared", key_busy, 1'b0);
  endtask

  task automatic t_stall_enable();
    do_reset();
    wr_key_hi = 1; wr_data = 32'h22222222; step(); wr_key_hi = 0;
    wr_mode = 1; mode_arg = 26'h1;
    #1 chk("R8 stall in window 1", stall_req, 1'b1);
    step();
    chk("R8 no enable while stalled", crypt_en, 1'b0);
    #1 chk("R8 stall in window 2", stall_req, 1'b1);
    step();
    #1 chk("R8 stall releases", stall_req, 1'b0);
    step(); idle();
    chk("R8 enable on third edge", crypt_en, 1'b1);
    #1 chk("R9 no stall when idle", stall_req, 1'b0);
  endtask

  task automatic t_stall_same_cycle();
    do_reset();
    wr_key_lo = 1; wr_data = 32'h3; wr_mode = 1; mode_arg = 26'h2000000;
    #1 chk("R8 stall with concurrent key write", stall_req, 1'b1);
    step(); idle();
    chk("R8 flag unchanged", crypt_en, 1'b0);
  endtask

  task automatic t_mode_enable_disable();
    do_reset();
    wr_mode = 1; mode_arg = 26'h3ffffff; step(); idle();
    chk("R6 nonzero enables", crypt_en, 1'b1);
    wr_key_lo = 1; wr_data = 32'h9; step(); wr_key_lo = 0;
    wr_mode = 1; mode_arg = 26'h0;
    #1 chk("R9 zero arg never stalls", stall_req, 1'b0);
    step(); idle();
    chk("R6 zero disables in window", crypt_en, 1'b0);
  endtask

  task automatic t_dual_write();
    do_reset();
    wr_key_lo = 1; wr_key_hi = 1; wr_data = 32'hcafef00d; step(); idle();
    chk("R10 both halves", key, 64'hcafef00d_cafef00d);
    chk("R5 valid same cycle", key_valid, 1'b1);
  endtask

  initial begin
    rst_n = 0;
    idle();
    t_reset();
    t_lo_then_hi();
    t_hold_and_mode();
    t_hi_then_lo_order();
    t_settle_window();
    t_stall_enable();
    t_stall_same_cycle();
    t_mode_enable_disable();
    t_dual_write();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule